// File: doc/BRIEF.md
# Cache Test-Mode Array Read Responder

This block answers array reads on a shared 64-bit address/data bus while the chip is in a cache test mode. An external agent puts a command word on the bus and pulls the active-low valid strobe for one bus cycle. The block picks the target out of that word: an array address, a way bit, an auto-increment flag, a write/read flag and a 3-bit array selector. When both flags are clear the command is a plain read. The block latches the target, waits a fixed latency counted in processor clocks, and then becomes bus master for exactly one bus cycle. In that cycle it drives the selected word with its own active-low valid strobe. In the next cycle it releases the bus.

Reads must stay a minimum number of processor clocks apart. A command that arrives inside that window is dropped, and it sets a sticky protocol-error flag. The bus is modelled as separate input, output and output-enable vectors, so the block fits behind a chip-level pad ring. The arrays are simple behavioural memories. A side-door port lets a testbench or loader fill them. A bus-clock enable marks the processor cycles in which the bus is sampled. It stays high when the two clocks run at the same rate.

Top module: `tmr_responder`

## Requirements
- R1: A command is taken only in a cycle where `validInN` is 0 and `busClkEn` is 1. A low strobe while `busClkEn` is 0 has no effect.
- R2: The command word is decoded as follows: array address in `busIn[57:46]`, way in bit 45, auto-increment flag in bit 44, write/read flag in bit 43, array selector in bits 42:40. All other bits are ignored.
- R3: A read starts only when bits 44 and 43 are both 0. Any other command produces no response and no error.
- R4: If a read is sampled at clock edge k, the response occupies the cycle between edges k+14 and k+15. That is 15 processor clocks after the command cycle.
- R5: During the response, `busOe` is 1 and `validOutN` is 0 for exactly one bus cycle. `busOut[39:0]` carries the selected word and `busOut[63:40]` is 0.
- R6: In every other cycle, `busOe` is 0, `validOutN` is 1 and `busOut` is 0. The bus is released in the cycle right after the response.
- R7: After an accepted read at edge k, the next command is accepted at edge k+17 or later.
- R8: A strobed command sampled before edge k+17 is ignored and sets `protoErr` to 1. The flag stays set until reset.
- R9: An array selector of `NUM_ARRAYS` or above returns an all-zero word. Only the low log2(`DEPTH`) address bits index the array.
- R10: Synchronous active-high `rst` sets `busOe` to 0, `validOutN` to 1, `busOut` to 0, `protoErr` to 0, and clears all counters.
- R11: When `preWe` is 1, `preData` is written on the clock edge to the word at `preAddr` in array `preArray`, way `preWay`. A later read of that location returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| busClkEn | input | 1 | High in processor cycles that end a bus cycle |
| busIn | input | 64 | Bus value seen from the pads |
| validInN | input | 1 | Incoming active-low valid strobe |
| busOut | output | 64 | Value driven onto the bus |
| busOe | output | 1 | Bus output enable (block is master) |
| validOutN | output | 1 | Outgoing active-low valid strobe |
| protoErr | output | 1 | Sticky repeat-interval violation flag |
| preWe | input | 1 | Preload write enable |
| preArray | input | 3 | Preload array selector |
| preWay | input | 1 | Preload way |
| preAddr | input | IDX_W | Preload word index |
| preData | input | 40 | Preload data |

## Verification
The bound checker tests the bus-ownership rules on every cycle. Output enable and outgoing strobe must always agree. The upper bus bits stay zero while driving, and the bus is quiet when not driving. Mastership ends after one bus cycle, the error flag never clears on its own, and any two responses are at least the repeat interval apart. What only the bench scenarios can show is whether the right word comes back in the exact latency cycle. The bench also shows that flagged and non-read commands are dropped, that the k+16 and k+17 boundary of the guard falls correctly, and that aliased or out-of-range selectors decode as required.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 40;
  localparam int BUS_W   = 64;
  localparam int ADDR_HI = 57;
  localparam int ADDR_LO = 46;
  localparam int WAY_BIT = 45;
  localparam int INC_BIT = 44;
  localparam int WR_BIT  = 43;
  localparam int ARR_HI  = 42;
  localparam int ARR_LO  = 40;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2
  } tmrState_e;

  typedef struct packed {
    logic capture;  // latch the command fields
    logic load;     // fetch the array word into the output register
    logic clear;    // drop the output register at the end of the response
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int LAT = 15,
  parameter int REP = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busClkEn,
  input  logic       validInN,
  input  logic       cmdIsRead,
  output tmrStrobe_t strobe,
  output logic       busOe,
  output logic       validOutN,
  output logic       protoErr
);
  localparam int LAT_W = $clog2(LAT + 1);
  localparam int GAP_W = $clog2(REP + 1);

  tmrState_e        state;
  logic [LAT_W-1:0] latCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             errQ;
  logic             cmdSeen;
  logic             blocked;
  logic             accept;

  always_comb begin
    cmdSeen        = busClkEn & ~validInN;
    blocked        = (gapCnt != '0) || (state != ST_IDLE);
    accept         = cmdSeen & ~blocked & cmdIsRead;
    strobe.capture = accept;
    strobe.load    = (state == ST_WAIT) && (latCnt == '0) && busClkEn;
    strobe.clear   = (state == ST_DRIVE) && busClkEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      latCnt <= '0;
      gapCnt <= '0;
      errQ   <= 1'b0;
    end else begin
      if (accept)              gapCnt <= GAP_W'(REP - 1);
      else if (gapCnt != '0)   gapCnt <= gapCnt - 1'b1;
      if (cmdSeen && blocked)  errQ   <= 1'b1;
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_WAIT;
          latCnt <= LAT_W'(LAT - 2);
        end
        ST_WAIT: begin
          if (latCnt != '0)  latCnt <= latCnt - 1'b1;
          else if (busClkEn) state  <= ST_DRIVE;
        end
        ST_DRIVE: if (busClkEn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busOe     = (state == ST_DRIVE);
  assign validOutN = ~(state == ST_DRIVE);
  assign protoErr  = errQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_ARRAYS = 2,
  parameter int DEPTH      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobe_t        strobe,
  input  logic [BUS_W-1:0]  busIn,
  output logic              cmdIsRead,
  output logic [BUS_W-1:0]  busOut,
  input  logic              preWe,
  input  logic [2:0]        preArray,
  input  logic              preWay,
  input  logic [$clog2(DEPTH)-1:0] preAddr,
  input  logic [DATA_W-1:0] preData
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BANKS  = NUM_ARRAYS * 2;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic [IDX_W-1:0]  selIdx;
  logic              selWay;
  logic [2:0]        selArr;
  logic [BUS_W-1:0]  outReg;
  logic [DATA_W-1:0] bankRd [BANKS];
  logic [DATA_W-1:0] rdData;
  logic [3:0]        selBankWide;
  logic [3:0]        preBankWide;
  logic              selInRange;
  logic              preInRange;

  assign cmdIsRead = ~busIn[INC_BIT] & ~busIn[WR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      selIdx <= '0;
      selWay <= 1'b0;
      selArr <= '0;
    end else if (strobe.capture) begin
      selIdx <= busIn[ADDR_LO +: IDX_W];
      selWay <= busIn[WAY_BIT];
      selArr <= busIn[ARR_HI:ARR_LO];
    end
  end

  assign preBankWide = {preArray, preWay};
  assign preInRange  = ({29'b0, preArray} < NUM_ARRAYS);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (preWe && preInRange && (preBankWide == 4'(b)))
        mem[preAddr] <= preData;
    end
    assign bankRd[b] = mem[selIdx];
  end

  assign selBankWide = {selArr, selWay};
  assign selInRange  = ({29'b0, selArr} < NUM_ARRAYS);
  assign rdData      = selInRange ? bankRd[selBankWide[BANK_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (rst)               outReg <= '0;
    else if (strobe.load)  outReg <= {{(BUS_W-DATA_W){1'b0}}, rdData};
    else if (strobe.clear) outReg <= '0;
  end

  assign busOut = outReg;
endmodule

// File: rtl/tmr_responder.sv
module tmr_responder
  import tmr_pkg::*;
#(
  parameter int NUM_ARRAYS = 2,
  parameter int DEPTH      = 64,
  parameter int LAT        = 15,
  parameter int REP        = 17,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busClkEn,
  input  logic [63:0]       busIn,
  input  logic              validInN,
  output logic [63:0]       busOut,
  output logic              busOe,
  output logic              validOutN,
  output logic              protoErr,
  input  logic              preWe,
  input  logic [2:0]        preArray,
  input  logic              preWay,
  input  logic [IDX_W-1:0]  preAddr,
  input  logic [39:0]       preData
);
  tmrStrobe_t strobe;
  logic       cmdIsRead;

  tmr_ctrl #(.LAT(LAT), .REP(REP)) u_ctrl (
    .clk(clk), .rst(rst), .busClkEn(busClkEn), .validInN(validInN),
    .cmdIsRead(cmdIsRead), .strobe(strobe), .busOe(busOe),
    .validOutN(validOutN), .protoErr(protoErr)
  );

  tmr_datapath #(.NUM_ARRAYS(NUM_ARRAYS), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .busIn(busIn),
    .cmdIsRead(cmdIsRead), .busOut(busOut), .preWe(preWe),
    .preArray(preArray), .preWay(preWay), .preAddr(preAddr),
    .preData(preData)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int REP = 17
) (
  input logic        clk,
  input logic        rst,
  input logic        busClkEn,
  input logic [63:0] busOut,
  input logic        busOe,
  input logic        validOutN,
  input logic        protoErr
);
  localparam int CNT_W = $clog2(REP + 2);
  logic [CNT_W-1:0] sinceResp;
  logic             seenResp;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceResp <= '0;
      seenResp  <= 1'b0;
    end else if (!validOutN && (sinceResp != '0 || !seenResp)) begin
      if (!seenResp || sinceResp != '0) begin
        sinceResp <= '0;
        seenResp  <= 1'b1;
      end
    end else if (sinceResp < CNT_W'(REP)) begin
      sinceResp <= sinceResp + 1'b1;
    end
  end

  // R5: enable and outgoing strobe always agree
  p_oe_matches_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    busOe == !validOutN);

  // R5: upper lanes are zero while driving
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    busOe |-> (busOut[63:40] == 24'h0));

  // R6: quiet bus when not master
  p_quiet_when_slave_r6: assert property (@(posedge clk) disable iff (rst)
    !busOe |-> (busOut == 64'h0));

  // R6: mastership ends after one bus cycle
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (busOe && busClkEn) |=> !busOe);

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr);

  // R7: responses never closer than the repeat interval
  p_resp_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(validOutN) |-> (!seenResp || sinceResp >= CNT_W'(REP - 1)));
endmodule

bind tmr_responder tmr_checker #(.REP(REP)) u_chk (
  .clk(clk), .rst(rst), .busClkEn(busClkEn), .busOut(busOut),
  .busOe(busOe), .validOutN(validOutN), .protoErr(protoErr)
);

// File: tb/tb_tmr_responder.sv
`timescale 1ns/1ps
module tb_tmr_responder;
  localparam int NARR = 2;
  localparam int DEP  = 64;
  localparam int IW   = $clog2(DEP);
  localparam int NVEC = 8;
  // {array[2:0], way, addr[11:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 12'd5},
    {3'd0, 1'b1, 12'd5},
    {3'd1, 1'b0, 12'd63},
    {3'd1, 1'b1, 12'd0},
    {3'd1, 1'b0, 12'h0C7},
    {3'd2, 1'b0, 12'd3},
    {3'd7, 1'b1, 12'd9},
    {3'd0, 1'b1, 12'hFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busClkEn = 1'b1;
  logic [63:0] busIn = 64'h0;
  logic        validInN = 1'b1;
  logic [63:0] busOut;
  logic        busOe;
  logic        validOutN;
  logic        protoErr;
  logic        preWe = 1'b0;
  logic [2:0]  preArray = 3'd0;
  logic        preWay = 1'b0;
  logic [IW-1:0] preAddr = '0;
  logic [39:0] preData = 40'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_responder #(.NUM_ARRAYS(NARR), .DEPTH(DEP)) dut (
    .clk(clk), .rst(rst), .busClkEn(busClkEn), .busIn(busIn),
    .validInN(validInN), .busOut(busOut), .busOe(busOe),
    .validOutN(validOutN), .protoErr(protoErr), .preWe(preWe),
    .preArray(preArray), .preWay(preWay), .preAddr(preAddr),
    .preData(preData)
  );

  function automatic logic [39:0] pat(input logic [2:0] a, input logic w,
                                      input logic [11:0] ad);
    return {8'h5A, 5'd0, a, 7'd0, w, 10'd0, ad[5:0]};
  endfunction

  function automatic logic [39:0] expWord(input logic [2:0] a, input logic w,
                                          input logic [11:0] ad);
    if (int'(a) >= NARR) return 40'h0;
    return pat(a, w, {6'd0, ad[5:0]});
  endfunction

  function automatic logic [63:0] mkCmd(input logic [2:0] a, input logic w,
                                        input logic [11:0] ad, input logic inc,
                                        input logic wr);
    logic [63:0] c;
    c = {6'h2A, ad, w, inc, wr, a, 40'hDE_ADBE_EF01};
    return c;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives at the current negedge for one cycle, returns at the next negedge
  task automatic issue(input logic [63:0] c);
    busIn    = c;
    validInN = 1'b0;
    @(negedge clk);
    validInN = 1'b1;
    busIn    = 64'hFFFF_0000_FFFF_0000;
  endtask

  // full read at current negedge n0; returns at n0+17
  task automatic doRead(input logic [2:0] a, input logic w, input logic [11:0] ad,
                        input string tag);
    logic [39:0] e;
    e = expWord(a, w, ad);
    issue(mkCmd(a, w, ad, 1'b0, 1'b0));
    repeat (13) @(negedge clk);
    check(busOe == 1'b0 && validOutN == 1'b1, {tag, " R4 early"},
          {62'd0, busOe, validOutN}, 64'd1);
    @(negedge clk);
    check(busOe == 1'b1 && validOutN == 1'b0, {tag, " R4 R5 strobe"},
          {62'd0, busOe, validOutN}, 64'd2);
    check(busOut == {24'h0, e}, {tag, " R2 R5 R9 data"}, busOut, {24'h0, e});
    @(negedge clk);
    check(busOe == 1'b0 && validOutN == 1'b1 && busOut == 64'h0, {tag, " R6 release"},
          busOut, 64'h0);
    @(negedge clk);
  endtask

  task automatic expectQuiet(input int n, input string tag);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busOe || !validOutN || busOut != 64'h0) bad = 1'b1;
    end
    check(!bad, tag, {63'd0, bad}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(busOe == 1'b0 && validOutN == 1'b1 && busOut == 64'h0 && protoErr == 1'b0,
          "R10 reset state", busOut, 64'h0);

    // R11: preload every bank
    for (int a = 0; a < NARR; a++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < DEP; i++) begin
          preWe = 1'b1; preArray = 3'(a); preWay = w[0]; preAddr = IW'(i);
          preData = pat(3'(a), w[0], 12'(i));
          @(negedge clk);
        end
    preWe = 1'b0;
    @(negedge clk);

    // vector table: back-to-back reads at the exact R7 boundary
    for (int v = 0; v < NVEC; v++)
      doRead(VEC[v][15:13], VEC[v][12], VEC[v][11:0], $sformatf("vec%0d", v));
    check(protoErr == 1'b0, "R7 k+17 accepted", {63'd0, protoErr}, 64'd0);

    // R3: write and auto-increment commands ignored
    issue(mkCmd(3'd0, 1'b0, 12'd1, 1'b0, 1'b1));
    expectQuiet(20, "R3 write ignored");
    issue(mkCmd(3'd0, 1'b0, 12'd1, 1'b1, 1'b0));
    expectQuiet(20, "R3 autoinc ignored");
    check(protoErr == 1'b0, "R3 no error", {63'd0, protoErr}, 64'd0);

    // R1: strobe without bus-clock enable ignored
    busClkEn = 1'b0;
    issue(mkCmd(3'd1, 1'b1, 12'd2, 1'b0, 1'b0));
    busClkEn = 1'b1;
    expectQuiet(20, "R1 no enable ignored");

    // R11: overwrite one word then read it
    preWe = 1'b1; preArray = 3'd1; preWay = 1'b1; preAddr = IW'(9);
    preData = 40'h12_3456_789A;
    @(negedge clk);
    preWe = 1'b0;
    begin
      issue(mkCmd(3'd1, 1'b1, 12'd9, 1'b0, 1'b0));
      repeat (14) @(negedge clk);
      check(busOut == {24'h0, 40'h12_3456_789A}, "R11 preload readback",
            busOut, {24'h0, 40'h12_3456_789A});
      repeat (3) @(negedge clk);
    end

    // R8: command at k+16 rejected and flagged
    issue(mkCmd(3'd0, 1'b0, 12'd4, 1'b0, 1'b0));
    repeat (14) @(negedge clk);
    check(busOe == 1'b1 && busOut == {24'h0, pat(3'd0, 1'b0, 12'd4)}, "R4 guard read",
          busOut, {24'h0, pat(3'd0, 1'b0, 12'd4)});
    @(negedge clk);
    issue(mkCmd(3'd1, 1'b0, 12'd4, 1'b0, 1'b0));
    check(protoErr == 1'b1, "R8 k+16 flagged", {63'd0, protoErr}, 64'd1);
    expectQuiet(20, "R8 early command dropped");

    // R8: command mid-latency dropped, first response intact, flag sticky
    issue(mkCmd(3'd0, 1'b1, 12'd7, 1'b0, 1'b0));
    repeat (4) @(negedge clk);
    issue(mkCmd(3'd1, 1'b1, 12'd8, 1'b0, 1'b0));
    repeat (9) @(negedge clk);
    check(busOe == 1'b1 && busOut == {24'h0, pat(3'd0, 1'b1, 12'd7)},
          "R8 original response kept", busOut, {24'h0, pat(3'd0, 1'b1, 12'd7)});
    expectQuiet(25, "R8 no second response");
    doRead(3'd1, 1'b0, 12'd10, "after error");
    check(protoErr == 1'b1, "R8 sticky", {63'd0, protoErr}, 64'd1);

    // R10: reset clears the flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(protoErr == 1'b0 && busOe == 1'b0, "R10 reset clears error",
          {63'd0, protoErr}, 64'd0);
    doRead(3'd0, 1'b0, 12'd33, "post reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule